// File: doc/BRIEF.md
# Interrupt-capable GPIO bank

This block is a single bank of general-purpose I/O pins behind a small word-wide register port. Software writes an output latch and a direction vector; the block drives the latch onto `pin_o` and the direction vector onto `pin_oe_o`, leaving the pads themselves to the surrounding logic. The synchronised level of every input pin can be read back at any time.

Every pin can raise an interrupt. Per pin, a sense-select bit picks between edge and level sensing. A second bit picks the active edge and a third bit picks the active level. Qualifying events set bits in a sticky event register. A mask register (a set bit silences the pin) gates those bits into a single bank interrupt line. Detection in both directions is left to software, which inverts the edge bit after each event. Four further registers (sleep output values, sleep mask, fault output values, alternate-function select) are plain storage for neighbouring logic.

Every write replaces a whole register. Single-bit updates are read-modify-write sequences run by software.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset the output latch, direction, edge-select, level-select, event and all storage registers read 0; the sense-select (index 3) and mask (index 6) registers read all ones; `irq_o` is low.
- R2: Register index map: 0 output latch, 1 direction, 2 pin level (read-only), 3 sense-select, 4 edge-select, 5 level-select, 6 mask, 7 event, 8 sleep outputs, 9 sleep mask, 10 fault outputs, 11 alternate select. A write replaces the whole addressed register and a read returns it. A write to index 2 has no effect, and indices 12 to 15 read 0.
- R3: `pin_o` equals the output latch and `pin_oe_o` equals the direction register (bit n set drives pin n), both from the edge after the write.
- R4: Index 2 returns `pin_i` through a two-flop synchroniser: a pin change is visible after the second rising clock edge and not after the first.
- R5: A pin whose sense-select bit is 1 is edge-sensitive. Edge-select 1 sets its event bit on a rising synchronised input and 0 on a falling one. The opposite edge sets nothing. The event bit is set on the third clock edge after the pin change.
- R6: A pin whose sense-select bit is 0 is level-sensitive. While its synchronised input equals its level-select bit, its event bit is set on every clock, so clearing it does not hold while the level stays active.
- R7: Event bits are sticky. A write to index 7 loads the written value OR the events of that cycle, so writing 0 clears all settled events.
- R8: `irq_o` is high exactly when some event bit is set whose mask bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe for the addressed register |
| addr_i | input | 4 | Register index |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i`, combinational |
| pin_i | input | 16 | Pin input levels, asynchronous |
| pin_o | output | 16 | Output latch value |
| pin_oe_o | output | 16 | Per-pin output enable |
| irq_o | output | 1 | Bank interrupt |

## Verification
The assertions take for granted that `wr_en_i`, `addr_i` and `wdata_i` are stable around the sampling edge. They also assume that `pin_i` changes only once the synchroniser has produced a clean value, so that a pin edge shows up at the detector as one clean step. The bench drives every input on the falling clock edge. It holds each pin pattern for at least three cycles before it checks events, and it issues event-clear writes only after the pin inputs have settled, so that no pin edge lands in the same cycle as a clear.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        REG_OUT      = 4'd0,
        REG_DIR      = 4'd1,
        REG_PIN      = 4'd2,
        REG_SENSE    = 4'd3,
        REG_EDGE     = 4'd4,
        REG_LEVEL    = 4'd5,
        REG_MASK     = 4'd6,
        REG_EVENT    = 4'd7,
        REG_SLP_OUT  = 4'd8,
        REG_SLP_MASK = 4'd9,
        REG_FLT_OUT  = 4'd10,
        REG_ALT      = 4'd11
    } reg_sel_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] chain_d [STAGES];
    logic [W-1:0] chain_q [STAGES];

    always_comb begin
        chain_d[0] = d_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int s = 0; s < STAGES; s++) begin
                chain_q[s] <= '0;
            end
        end else begin
            for (int s = 0; s < STAGES; s++) begin
                chain_q[s] <= chain_d[s];
            end
        end
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_event.sv
module gpio_event #(
    parameter int W = 16
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] lvl_i,
    input  logic [W-1:0] sense_i,
    input  logic [W-1:0] edge_sel_i,
    input  logic [W-1:0] level_sel_i,
    output logic [W-1:0] hit_o,
    output logic [W-1:0] prev_o
);

    logic [W-1:0] prev_d;
    logic [W-1:0] prev_q;

    always_comb begin
        prev_d = lvl_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            prev_q <= '0;
        end else begin
            prev_q <= prev_d;
        end
    end

    for (genvar p = 0; p < W; p++) begin : g_pin
        logic rise;
        logic fall;
        logic edge_hit;
        logic level_hit;
        assign rise      = lvl_i[p] & ~prev_q[p];
        assign fall      = ~lvl_i[p] & prev_q[p];
        assign edge_hit  = edge_sel_i[p] ? rise : fall;
        assign level_hit = (lvl_i[p] == level_sel_i[p]);
        assign hit_o[p]  = sense_i[p] ? edge_hit : level_hit;
    end

    assign prev_o = prev_q;

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 16
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                wr_en_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [NPINS-1:0]    wdata_i,
    output logic [NPINS-1:0]    rdata_o,
    input  logic [NPINS-1:0]    pin_i,
    output logic [NPINS-1:0]    pin_o,
    output logic [NPINS-1:0]    pin_oe_o,
    output logic                irq_o
);

    typedef struct packed {
        logic [NPINS-1:0] out;
        logic [NPINS-1:0] dir;
        logic [NPINS-1:0] sense;
        logic [NPINS-1:0] edge_sel;
        logic [NPINS-1:0] level_sel;
        logic [NPINS-1:0] mask;
        logic [NPINS-1:0] evt;
        logic [NPINS-1:0] slp_out;
        logic [NPINS-1:0] slp_mask;
        logic [NPINS-1:0] flt_out;
        logic [NPINS-1:0] alt;
    } bank_regs_t;

    localparam bank_regs_t RESET_VAL = '{
        out:       '0,
        dir:       '0,
        sense:     '1,
        edge_sel:  '0,
        level_sel: '0,
        mask:      '1,
        evt:       '0,
        slp_out:   '0,
        slp_mask:  '0,
        flt_out:   '0,
        alt:       '0
    };

    bank_regs_t       regs_d;
    bank_regs_t       regs_q;
    logic [NPINS-1:0] pin_sync;
    logic [NPINS-1:0] pin_prev;
    logic [NPINS-1:0] hit;

    gpio_sync #(
        .W      (NPINS),
        .STAGES (2)
    ) i_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (pin_i),
        .q_o    (pin_sync)
    );

    gpio_event #(
        .W (NPINS)
    ) i_event (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .lvl_i       (pin_sync),
        .sense_i     (regs_q.sense),
        .edge_sel_i  (regs_q.edge_sel),
        .level_sel_i (regs_q.level_sel),
        .hit_o       (hit),
        .prev_o      (pin_prev)
    );

    always_comb begin
        regs_d = regs_q;
        if (wr_en_i) begin
            case (reg_sel_e'(addr_i))
                REG_OUT:      regs_d.out       = wdata_i;
                REG_DIR:      regs_d.dir       = wdata_i;
                REG_SENSE:    regs_d.sense     = wdata_i;
                REG_EDGE:     regs_d.edge_sel  = wdata_i;
                REG_LEVEL:    regs_d.level_sel = wdata_i;
                REG_MASK:     regs_d.mask      = wdata_i;
                REG_EVENT:    regs_d.evt       = wdata_i;
                REG_SLP_OUT:  regs_d.slp_out   = wdata_i;
                REG_SLP_MASK: regs_d.slp_mask  = wdata_i;
                REG_FLT_OUT:  regs_d.flt_out   = wdata_i;
                REG_ALT:      regs_d.alt       = wdata_i;
                default: ;
            endcase
        end
        regs_d.evt = regs_d.evt | hit;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            regs_q <= RESET_VAL;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        case (reg_sel_e'(addr_i))
            REG_OUT:      rdata_o = regs_q.out;
            REG_DIR:      rdata_o = regs_q.dir;
            REG_PIN:      rdata_o = pin_sync;
            REG_SENSE:    rdata_o = regs_q.sense;
            REG_EDGE:     rdata_o = regs_q.edge_sel;
            REG_LEVEL:    rdata_o = regs_q.level_sel;
            REG_MASK:     rdata_o = regs_q.mask;
            REG_EVENT:    rdata_o = regs_q.evt;
            REG_SLP_OUT:  rdata_o = regs_q.slp_out;
            REG_SLP_MASK: rdata_o = regs_q.slp_mask;
            REG_FLT_OUT:  rdata_o = regs_q.flt_out;
            REG_ALT:      rdata_o = regs_q.alt;
            default:      rdata_o = '0;
        endcase
    end

    assign pin_o    = regs_q.out;
    assign pin_oe_o = regs_q.dir;
    assign irq_o    = |(regs_q.evt & ~regs_q.mask);

endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk
    import gpio_irq_pkg::*;
#(
    parameter int W = 16
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              wr_en_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [W-1:0]      wdata_i,
    input logic [W-1:0]      pin_o,
    input logic [W-1:0]      pin_oe_o,
    input logic              irq_o,
    input logic [W-1:0]      evt,
    input logic [W-1:0]      mask,
    input logic [W-1:0]      sense,
    input logic [W-1:0]      edge_sel,
    input logic [W-1:0]      level_sel,
    input logic [W-1:0]      sync,
    input logic [W-1:0]      prev
);

    logic [W-1:0] edge_seen;
    logic [W-1:0] level_seen;
    logic [W-1:0] edge_seen_q;
    logic [W-1:0] level_seen_q;

    assign edge_seen  = sense & ((edge_sel & sync & ~prev) | (~edge_sel & ~sync & prev));
    assign level_seen = ~sense & ~(sync ^ level_sel);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            edge_seen_q  <= '0;
            level_seen_q <= '0;
        end else begin
            edge_seen_q  <= edge_seen;
            level_seen_q <= level_seen;
        end
    end

    p_out_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_i == REG_OUT) |=> (pin_o == $past(wdata_i)));

    p_dir_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_i == REG_DIR) |=> (pin_oe_o == $past(wdata_i)));

    p_edge_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((edge_seen_q & ~evt) == '0));

    p_level_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((level_seen_q & ~evt) == '0));

    p_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(wr_en_i && addr_i == REG_EVENT) |=> (($past(evt) & ~evt) == '0));

    p_masked_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mask == '1) |-> !irq_o);

    p_no_event_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt == '0) |-> !irq_o);

endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.W(NPINS)) i_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .pin_o     (pin_o),
    .pin_oe_o  (pin_oe_o),
    .irq_o     (irq_o),
    .evt       (regs_q.evt),
    .mask      (regs_q.mask),
    .sense     (regs_q.sense),
    .edge_sel  (regs_q.edge_sel),
    .level_sel (regs_q.level_sel),
    .sync      (pin_sync),
    .prev      (pin_prev)
);

// File: tb/test_gpio_irq_bank.sv
`timescale 1ns/1ps
module test_gpio_irq_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [3:0]  addr = 4'd0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [15:0] pins = '0;
    logic [15:0] pout;
    logic [15:0] poe;
    logic        irq;
    int          tests = 0;
    int          fails = 0;

    always #5 clk = ~clk;

    gpio_irq_bank #(.NPINS(16)) i_gpio_irq_bank (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .wr_en_i  (we),
        .addr_i   (addr),
        .wdata_i  (wdata),
        .rdata_o  (rdata),
        .pin_i    (pins),
        .pin_o    (pout),
        .pin_oe_o (poe),
        .irq_o    (irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic [15:0] lp;
        logic [15:0] pv;
        int regs_list[10] = '{0, 1, 3, 4, 5, 6, 8, 9, 10, 11};
        logic [15:0] pats[4] = '{16'h0000, 16'hFFFF, 16'h5A3C, 16'hC3A5};

        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1: reset values
        rd(4'd0, v);  chk("R1 out", v, 16'h0000);
        rd(4'd1, v);  chk("R1 dir", v, 16'h0000);
        rd(4'd3, v);  chk("R1 sense", v, 16'hFFFF);
        rd(4'd4, v);  chk("R1 edge", v, 16'h0000);
        rd(4'd5, v);  chk("R1 level", v, 16'h0000);
        rd(4'd6, v);  chk("R1 mask", v, 16'hFFFF);
        rd(4'd7, v);  chk("R1 event", v, 16'h0000);
        for (int r = 8; r < 12; r++) begin
            rd(4'(r), v); chk("R1 storage", v, 16'h0000);
        end
        chk("R1 irq", {15'd0, irq}, 16'd0);
        chk("R1 pin_o", pout, 16'h0000);
        chk("R1 pin_oe", poe, 16'h0000);

        // R2 / R3: full-register write and readback sweep
        foreach (regs_list[k]) begin
            for (int p = 0; p < 4; p++) begin
                wr(4'(regs_list[k]), pats[p]);
                rd(4'(regs_list[k]), v);
                chk("R2 readback", v, pats[p]);
                if (regs_list[k] == 0) chk("R3 pin_o", pout, pats[p]);
                if (regs_list[k] == 1) chk("R3 pin_oe", poe, pats[p]);
            end
        end
        for (int r = 12; r < 16; r++) begin
            rd(4'(r), v); chk("R2 unmapped", v, 16'h0000);
        end

        // R4: synchronised pin readback
        for (int k = 0; k < 8; k++) begin
            pins = 16'(k * 16'h3C71 ^ 16'h0F0F);
            idle(3);
            rd(4'd2, v); chk("R4 pin level", v, pins);
        end
        pins = 16'h1234;
        idle(3);
        wr(4'd2, 16'hFFFF);
        rd(4'd2, v); chk("R2 pin write ignored", v, 16'h1234);

        // R4 / R5 latency: rising edge on pin 0
        wr(4'd3, 16'hFFFF);
        wr(4'd4, 16'hFFFF);
        pins = 16'h0000;
        idle(4);
        wr(4'd7, 16'h0000);
        wr(4'd6, 16'hFFFE);
        addr = 4'd2;
        @(negedge clk);
        pins = 16'h0001;
        @(posedge clk); @(negedge clk);
        #1 chk("R4 not after first edge", rdata, 16'h0000);
        @(posedge clk); @(negedge clk);
        #1 chk("R4 after second edge", rdata, 16'h0001);
        chk("R5 no event before third edge", {15'd0, irq}, 16'd0);
        @(posedge clk); @(negedge clk);
        chk("R5 event after third edge", {15'd0, irq}, 16'd1);

        // R5: every pin, both edge selects, both pin motions
        for (int i = 0; i < 16; i++) begin
            for (int pol = 0; pol < 2; pol++) begin
                for (int up = 0; up < 2; up++) begin
                    wr(4'd4, pol ? 16'hFFFF : 16'h0000);
                    wr(4'd6, ~(16'd1 << i));
                    pins = up ? 16'h0000 : 16'hFFFF;
                    idle(4);
                    wr(4'd7, 16'h0000);
                    pins[i] = ~pins[i];
                    idle(4);
                    rd(4'd7, v);
                    chk("R5 edge event", v, (pol == up) ? (16'd1 << i) : 16'd0);
                    chk("R8 irq edge", {15'd0, irq}, {15'd0, (pol == up)});
                end
            end
        end

        // R6 / R7: level sensing and clearing
        wr(4'd3, 16'h0000);
        for (int k = 0; k < 6; k++) begin
            lp = 16'(k * 16'h1357 ^ 16'h0F0F);
            pv = 16'(k * 16'h2469);
            wr(4'd5, lp);
            pins = pv;
            idle(4);
            wr(4'd7, 16'h0000);
            idle(2);
            rd(4'd7, v);
            chk("R6 level held after clear", v, ~(pv ^ lp));
            pins = ~lp;
            idle(4);
            wr(4'd7, 16'h0000);
            idle(1);
            rd(4'd7, v);
            chk("R7 clear when inactive", v, 16'h0000);
        end

        // R7: write loads value, stays sticky
        wr(4'd7, 16'h8421);
        idle(3);
        rd(4'd7, v); chk("R7 loaded value sticks", v, 16'h8421);

        // R8: masking
        wr(4'd5, 16'hA5A5);
        pins = 16'h0FF0;
        idle(4);
        wr(4'd7, 16'h0000);
        wr(4'd6, 16'hFFFF);
        rd(4'd7, v); chk("R6 level pattern", v, 16'h55AA);
        chk("R8 all masked", {15'd0, irq}, 16'd0);
        wr(4'd6, ~16'h0002);
        chk("R8 unmasked set bit", {15'd0, irq}, 16'd1);
        wr(4'd6, ~16'h0001);
        chk("R8 unmasked clear bit", {15'd0, irq}, 16'd0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule